// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter behind a small 32-bit write/read register window. Software programs a timeout, turns the counter on and must keep sending a restart command before the count runs out. The counter steps on a slow tick enable, nominally 32 kHz. The timeout is given in units of a configurable number of ticks, 512 by default. If software stops sending restarts, the block does one of three things, depending on the mode. It pulses a system reset output, or it raises an interrupt, or it raises an interrupt first and resets on a second miss.

Every register write that changes behaviour must carry a fixed key value. A write with a wrong key has no effect. A separate software command starts the reset pulse at once, whatever the counter holds. A status register records whether the last reset came from a timeout or from the software command.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, all mode bits are 0, the timeout field is all ones, status reads 0, `irq` is 0 and `wdtRst` is 1 (the inactive level for active-low polarity).
- R2: The mode register is at byte offset 0x00. A write updates it only when bits 31:24 equal 0x22. The fields are enable (bit 0), polarity (bit 1), output enable (bit 2), interrupt enable (bit 3) and dual mode (bit 6). Readback returns the fields at the same bits, with all other bits 0. A write with any other key leaves the register unchanged.
- R3: The length register is at byte offset 0x04. A write updates it only when bits 4:0 equal 0x08. The timeout value is bits 5+TW-1:5, and readback returns it in those bits with all other bits 0. A write with any other key leaves the value unchanged.
- R4: The counter is loaded from the timeout value L when enable goes from 0 to 1, or on a restart. It expires on the max(L,1)*TPU-th tick after the load. While enable is 0, ticks do not advance it.
- R5: A write to the length register does not change the count already running. The new value is used at the next load.
- R6: Writing exactly 0x00001971 to byte offset 0x08 reloads the counter. Any other value written there is ignored.
- R7: With interrupt enable 0 and dual mode 0, expiry starts a reset pulse that lasts exactly PULSE ticks. It also sets status bit 31 and reloads the counter.
- R8: `wdtRst` carries the pulse only when output enable is 1. It is active high when polarity is 1 and active low when polarity is 0. At all other times it sits at the inactive level (the inverse of the polarity bit).
- R9: Writing exactly 0x00001209 to byte offset 0x14 starts the reset pulse in the next cycle and sets status bit 30. Other values written there are ignored.
- R10: With interrupt enable 1 and dual mode 0, expiry sets `irq` and gives no reset pulse. The counter then holds until a restart, and the restart clears `irq`.
- R11: With dual mode 1, the first expiry sets `irq` and reloads the counter. The next expiry, with no restart in between, gives a reset pulse and clears `irq`.
- R12: The status register is at byte offset 0x0C. Any mode write with the correct key clears status bits 31 and 30. A mode write with a wrong key leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle counting tick enable (32 kHz rate) |
| wrEn | input | 1 | Register write strobe |
| addr | input | AW | Byte address for both write and read |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Expiry interrupt, level |
| wdtRst | output | 1 | Reset output, polarity selectable |

## Verification
The bench builds the block with a 4-bit timeout field, 4 ticks per unit and a 3-tick reset pulse. With these values every timeout value from 0 to 15 can be swept. For each one, the bench checks that the output is quiet one tick before max(L,1)*4 and fires on exactly that tick, then times the pulse tick by tick. The short units also keep the runs for restart, late length writes, the interrupt-only hold and the second-miss dual path to a few dozen ticks each, so every mode and both polarities are reached in one short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0]  OFF_MODE    = 8'h00;
  localparam logic [7:0]  OFF_LEN     = 8'h04;
  localparam logic [7:0]  OFF_RESTART = 8'h08;
  localparam logic [7:0]  OFF_STATUS  = 8'h0C;
  localparam logic [7:0]  OFF_SWRST   = 8'h14;
  localparam logic [7:0]  MODE_KEY    = 8'h22;
  localparam logic [4:0]  LEN_KEY     = 5'h08;
  localparam logic [31:0] RESTART_VAL = 32'h0000_1971;
  localparam logic [31:0] SWRST_VAL   = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic irqEn;
    logic oe;
    logic pol;
    logic en;
  } modeCfg_t;

  typedef struct packed {
    logic reload;
    logic swKick;
    logic irqClr;
  } dpStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wrData,
  input  logic          toEvent,
  output modeCfg_t      cfg,
  output logic [TW-1:0] lenVal,
  output dpStrobe_t     stb,
  output logic [31:0]   rdData
);
  logic modeHit, lenHit, restartHit, swHit;
  logic stTimeout, stSoft;

  assign modeHit    = wrEn && (addr == AW'(OFF_MODE)) && (wrData[31:24] == MODE_KEY);
  assign lenHit     = wrEn && (addr == AW'(OFF_LEN)) && (wrData[4:0] == LEN_KEY);
  assign restartHit = wrEn && (addr == AW'(OFF_RESTART)) && (wrData == RESTART_VAL);
  assign swHit      = wrEn && (addr == AW'(OFF_SWRST)) && (wrData == SWRST_VAL);

  always_comb begin
    stb.reload = restartHit || (modeHit && wrData[0] && !cfg.en);
    stb.swKick = swHit;
    stb.irqClr = modeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      lenVal    <= '1;
      stTimeout <= 1'b0;
      stSoft    <= 1'b0;
    end else begin
      if (modeHit) begin
        cfg.en    <= wrData[0];
        cfg.pol   <= wrData[1];
        cfg.oe    <= wrData[2];
        cfg.irqEn <= wrData[3];
        cfg.dual  <= wrData[6];
      end
      if (lenHit) lenVal <= wrData[5 +: TW];
      if (modeHit) begin
        stTimeout <= 1'b0;
        stSoft    <= 1'b0;
      end else begin
        if (toEvent) stTimeout <= 1'b1;
        if (swHit)   stSoft    <= 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == AW'(OFF_MODE))
      rdData = {25'b0, cfg.dual, 2'b0, cfg.irqEn, cfg.oe, cfg.pol, cfg.en};
    else if (addr == AW'(OFF_LEN))
      rdData = 32'(lenVal) << 5;
    else if (addr == AW'(OFF_STATUS))
      rdData = {stTimeout, stSoft, 30'b0};
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int TW    = 11,
  parameter int TPU   = 512,
  parameter int PULSE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  modeCfg_t      cfg,
  input  logic [TW-1:0] lenVal,
  input  dpStrobe_t     stb,
  output logic          irq,
  output logic          rstActive,
  output logic          toEvent
);
  localparam int PW = (TPU > 1) ? $clog2(TPU) : 1;
  localparam int QW = $clog2(PULSE + 1);

  logic [PW-1:0] pre;
  logic [TW-1:0] cnt;
  logic [QW-1:0] pulseCnt;
  logic halted, irqQ;
  logic running, unitWrap, expire, irqOnly, firstDual, irqSet;

  assign running   = tick && cfg.en && !halted;
  assign unitWrap  = running && (pre == PW'(TPU - 1));
  assign expire    = unitWrap && (cnt <= TW'(1)) && !stb.reload;
  assign irqOnly   = cfg.irqEn && !cfg.dual;
  assign firstDual = cfg.dual && !irqQ;
  assign irqSet    = expire && (irqOnly || firstDual);
  assign toEvent   = expire && !irqOnly && !firstDual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre    <= '0;
      cnt    <= '1;
      halted <= 1'b0;
    end else if (stb.reload) begin
      pre    <= '0;
      cnt    <= lenVal;
      halted <= 1'b0;
    end else if (expire) begin
      pre <= '0;
      if (irqOnly) halted <= 1'b1;
      else         cnt    <= lenVal;
    end else if (unitWrap) begin
      pre <= '0;
      cnt <= cnt - TW'(1);
    end else if (running) begin
      pre <= pre + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           irqQ <= 1'b0;
    else if (stb.reload || stb.irqClr)   irqQ <= 1'b0;
    else if (irqSet)                     irqQ <= 1'b1;
    else if (toEvent)                    irqQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            pulseCnt <= '0;
    else if (stb.swKick || toEvent)       pulseCnt <= QW'(PULSE);
    else if (tick && (pulseCnt != '0))    pulseCnt <= pulseCnt - QW'(1);
  end

  assign irq       = irqQ;
  assign rstActive = (pulseCnt != '0);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int AW    = 8,
  parameter int TW    = 11,
  parameter int TPU   = 512,
  parameter int PULSE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wrData,
  output logic [31:0]   rdData,
  output logic          irq,
  output logic          wdtRst
);
  modeCfg_t      cfg;
  dpStrobe_t     stb;
  logic [TW-1:0] lenVal;
  logic          toEvent, rstActive;

  wdog_ctrl #(.AW(AW), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .toEvent(toEvent), .cfg(cfg), .lenVal(lenVal), .stb(stb), .rdData(rdData)
  );

  wdog_dp #(.TW(TW), .TPU(TPU), .PULSE(PULSE)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .cfg(cfg), .lenVal(lenVal),
    .stb(stb), .irq(irq), .rstActive(rstActive), .toEvent(toEvent)
  );

  assign wdtRst = cfg.pol ? (rstActive && cfg.oe) : !(rstActive && cfg.oe);
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int AW = 8,
  parameter int TW = 11
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic [31:0]   wrData,
  input modeCfg_t      cfg,
  input logic [TW-1:0] lenVal,
  input logic          rstActive,
  input logic          wdtRst
);
  // R2
  mode_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AW'(OFF_MODE) && wrData[31:24] != MODE_KEY) |=> $stable(cfg));

  // R3
  len_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AW'(OFF_LEN) && wrData[4:0] != LEN_KEY) |=> $stable(lenVal));

  // R9
  sw_kick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == AW'(OFF_SWRST) && wrData == SWRST_VAL) |=> rstActive);

  // R8
  out_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.oe |-> (wdtRst == !cfg.pol));
endmodule

bind wdog_keyed wdog_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cfg(cfg), .lenVal(lenVal), .rstActive(rstActive), .wdtRst(wdtRst)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
  localparam int AW = 8, TW = 4, TPU = 4, PULSE = 3;
  localparam logic [31:0] KEY = 32'h2200_0000;
  localparam logic [31:0] EN = 32'h1, POL = 32'h2, OE = 32'h4, IRQE = 32'h8, DUAL = 32'h40;

  logic clk = 0, rstN = 0, tick = 0, wrEn = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq, wdtRst;
  int total = 0, fails = 0;
  bit done = 0;

  wdog_keyed #(.AW(AW), .TW(TW), .TPU(TPU), .PULSE(PULSE)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wdtRst(wdtRst)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0; addr = '0; wrData = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic drain();
    wr(8'h00, KEY);
    tk(PULSE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 wdtRst", 32'(wdtRst), 1);
    chk("R1 irq", 32'(irq), 0);
    rd(8'h0C, v); chk("R1 status", v, 0);
    rd(8'h04, v); chk("R1 length", v, 32'(15) << 5);
    rd(8'h00, v); chk("R1 mode", v, 0);

    // R4 R7 R3: sweep every timeout value, active-high output
    for (int L = 0; L < 16; L++) begin
      int n;
      n = ((L == 0) ? 1 : L) * TPU;
      wr(8'h00, KEY);
      wr(8'h04, (32'(L) << 5) | 32'h8);
      rd(8'h04, v); chk("R3 length readback", v, 32'(L) << 5);
      wr(8'h00, KEY | EN | OE | POL);
      tk(n - 1); chk("R4 quiet before expiry", 32'(wdtRst), 0);
      tk(1);     chk("R4 fires at expiry", 32'(wdtRst), 1);
      rd(8'h0C, v); chk("R7 status timeout bit", v, 32'h8000_0000);
      tk(PULSE - 1); chk("R7 pulse held", 32'(wdtRst), 1);
      tk(1);         chk("R7 pulse ends", 32'(wdtRst), 0);
    end

    // R2 key checks and field positions
    wr(8'h00, KEY);
    wr(8'h00, 32'h2300_0000 | EN);
    rd(8'h00, v); chk("R2 wrong key ignored", v, 0);
    wr(8'h00, KEY | 32'h4F);
    rd(8'h00, v); chk("R2 field readback", v, 32'h4F);
    wr(8'h00, KEY);
    // R3 wrong key on length
    wr(8'h04, (32'd3 << 5) | 32'h9);
    rd(8'h04, v); chk("R3 wrong key ignored", v, 32'(15) << 5);

    // R5 length write does not reload running count
    wr(8'h04, (32'd3 << 5) | 32'h8);
    wr(8'h00, KEY | EN | OE | POL);
    tk(4);
    wr(8'h04, (32'd1 << 5) | 32'h8);
    tk(7); chk("R5 no early expiry", 32'(wdtRst), 0);
    tk(1); chk("R5 original timeout", 32'(wdtRst), 1);
    drain();

    // R6 restart
    wr(8'h04, (32'd2 << 5) | 32'h8);
    wr(8'h00, KEY | EN | OE | POL);
    tk(6); wr(8'h08, 32'h1970);
    tk(1); chk("R6 wrong restart quiet", 32'(wdtRst), 0);
    tk(1); chk("R6 wrong restart ignored", 32'(wdtRst), 1);
    drain();
    wr(8'h00, KEY | EN | OE | POL);
    tk(6); wr(8'h08, 32'h1971);
    tk(7); chk("R6 restart delays", 32'(wdtRst), 0);
    tk(1); chk("R6 expiry after restart", 32'(wdtRst), 1);
    drain();

    // R8 polarity and output enable
    wr(8'h04, (32'd1 << 5) | 32'h8);
    wr(8'h00, KEY | EN | OE);
    chk("R8 low-active idle", 32'(wdtRst), 1);
    tk(4); chk("R8 low-active pulse", 32'(wdtRst), 0);
    drain();
    wr(8'h00, KEY | EN | POL);
    tk(4); chk("R8 gated off", 32'(wdtRst), 0);
    rd(8'h0C, v); chk("R8 timeout still seen", v, 32'h8000_0000);
    drain();

    // R9 software reset
    wr(8'h00, KEY | OE | POL);
    wr(8'h14, 32'h1208);
    chk("R9 wrong value ignored", 32'(wdtRst), 0);
    wr(8'h14, 32'h1209);
    chk("R9 immediate pulse", 32'(wdtRst), 1);
    rd(8'h0C, v); chk("R9 status soft bit", v, 32'h4000_0000);
    tk(PULSE); chk("R9 pulse ends", 32'(wdtRst), 0);
    drain();

    // R10 interrupt only
    wr(8'h00, KEY | EN | OE | POL | IRQE);
    tk(4); chk("R10 irq raised", 32'(irq), 1);
    chk("R10 no reset", 32'(wdtRst), 0);
    tk(8); chk("R10 held, still no reset", 32'(wdtRst), 0);
    chk("R10 irq held", 32'(irq), 1);
    rd(8'h0C, v); chk("R10 no timeout status", v, 0);
    wr(8'h08, 32'h1971);
    chk("R10 restart clears irq", 32'(irq), 0);
    tk(4); chk("R10 counter resumed", 32'(irq), 1);
    drain();

    // R11 dual mode
    wr(8'h00, KEY | EN | OE | POL | DUAL);
    tk(4); chk("R11 first expiry irq", 32'(irq), 1);
    chk("R11 first expiry no reset", 32'(wdtRst), 0);
    tk(3); chk("R11 quiet before second", 32'(wdtRst), 0);
    tk(1); chk("R11 second expiry reset", 32'(wdtRst), 1);
    chk("R11 irq cleared", 32'(irq), 0);

    // R12 status clearing
    rd(8'h0C, v); chk("R12 status set", v, 32'h8000_0000);
    wr(8'h00, 32'h2100_0000);
    rd(8'h0C, v); chk("R12 wrong key keeps status", v, 32'h8000_0000);
    wr(8'h00, KEY);
    rd(8'h0C, v); chk("R12 keyed write clears", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule